// File: doc/BRIEF.md
# Interrupt-Triggered Data Transfer Engine

This block is a single-channel transfer engine placed between one peripheral's interrupt request line and the CPU. While its enable bit is set, it takes each new request from the peripheral in place of the CPU. For each request it reads one unit from a source address, writes that unit to a destination address, steps both addresses as their modes select, and counts one transfer off a loaded total. For every transfer except the last, it also pulses a clear to the peripheral's ready flag. After the final transfer it leaves the peripheral flag alone, drops its own enable, and lets the request through to the CPU, which then does the wrap-up work.

Software sets the engine up through a small register-write port: a mode word, the two addresses, the transfer count and the enable. Data moves over a single-port memory bus with a valid/ready handshake. The engine raises `mem_valid` with the address, direction and write data, and it holds all of them unchanged until the cycle in which `mem_ready` is high. That cycle completes the access. For a read, `mem_rdata` is taken in that same cycle. The memory side may hold `mem_ready` low for any number of cycles to apply back-pressure. The engine never drops or changes a request that it has already offered.

A typical use drains a receive data register at a fixed address into a run of consecutive RAM locations. The CPU is interrupted once the whole block has arrived.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset, `busy`, `mem_valid` and `flag_clr` are 0 and the enable bit is 0, so `cpu_irq` equals `periph_req`.
- R2: While the enable bit (register select 4, data bit 0) is 0, `cpu_irq` follows `periph_req` and no bus access is made.
- R3: With the enable bit set, a rising edge on `periph_req` while idle is accepted at the next clock edge, so `busy` is 1 one cycle later. The engine then performs one read at the source address and one write of the read data to the destination address. `busy` stays high until the register update after the write.
- R4: The mode word (register select 0) holds the source step mode in bits [1:0] and the destination step mode in bits [3:2]. A mode of 2'b00 or 2'b01 leaves the address fixed, 2'b10 increments it after each transfer, and 2'b11 decrements it. The source address is written with select 1 and the destination address with select 2.
- R5: Mode-word bit 4 selects the unit size: 0 is byte and 1 is word. The step is 1 for byte and 2 for word, and `mem_size` shows the size. Addresses wrap modulo 2^ADDR_W. In byte size the written data carries the low 8 bits of the read data, with the upper bits zero.
- R6: A transfer that does not bring the count (register select 3) to zero ends with `flag_clr` high for exactly one cycle, the update cycle, and `cpu_irq` stays 0.
- R7: The transfer that brings the count to zero does not pulse `flag_clr` and clears the enable bit. After it, `cpu_irq` is 1 for as long as `periph_req` stays high, and further requests start no transfer.
- R8: Once `mem_valid` is high with `mem_ready` low, the next cycle keeps `mem_valid` high with the same `mem_addr`, `mem_we` and `mem_wdata`. A read is always followed by its write in the next cycle.
- R9: A rising edge on `periph_req` that arrives while a transfer is in progress is held pending and serviced right after that transfer ends.
- R10: Register writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 mode, 1 source, 2 destination, 3 count, 4 enable |
| cfg_wdata | input | CFG_W | Register write data |
| periph_req | input | 1 | Peripheral ready flag / interrupt request (level) |
| flag_clr | output | 1 | One-cycle clear of the peripheral ready flag |
| cpu_irq | output | 1 | Interrupt request forwarded to the CPU |
| busy | output | 1 | Transfer in progress |
| mem_valid | output | 1 | Bus access offered |
| mem_ready | input | 1 | Bus access accepted this cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_size | output | 1 | 0 byte, 1 word |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | DATA_W | Bus write data |
| mem_rdata | input | DATA_W | Bus read data, taken when valid and ready |

## Verification
The main function is tried with four kinds of pattern: a fixed source drained into an incrementing destination (the receive-buffer case), decrementing pairs in word size, incrementing addresses that cross the top of the address space, and random mode, size, address and count mixes under random back-pressure. The fixed-versus-stepping patterns separate the two address updaters and their step sizes. The wrap patterns expose carry errors at the address boundary. Random `mem_ready` gaps test that bus requests are held and that read data is captured in the correct cycle. Directed runs check count-of-one and last-transfer hand-off, requests that arrive mid-transfer, and register writes made while busy, which distinguishes pending and ignore logic from an engine that simply drops or accepts everything.

// File: rtl/irq_xfer_pkg.sv
package irq_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_UPD  = 2'd3
  } xfer_state_e;

  localparam logic [2:0] SEL_MODE = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_EN   = 3'd4;

  localparam int NUM_PTR = 2;   // 0: source, 1: destination

endpackage

// File: rtl/irq_xfer_cfg.sv
module irq_xfer_cfg
  import irq_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              busy,
  input  logic              upd,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              word_size,
  output logic              en,
  output logic              last
);

  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
  localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);

  logic              wr_ok;
  logic [CNT_W-1:0]  cnt_q;
  logic              size_q;
  logic              en_q;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] ptr_q [NUM_PTR];

  assign wr_ok = cfg_we && !busy;
  assign step  = size_q ? STEP_WORD : STEP_BYTE;

  genvar g;
  generate
    for (g = 0; g < NUM_PTR; g++) begin : g_ptr
      logic [1:0]        mode_q;
      logic [ADDR_W-1:0] nxt;

      always_comb begin
        unique case (mode_q)
          2'b10:   nxt = ptr_q[g] + step;
          2'b11:   nxt = ptr_q[g] - step;
          default: nxt = ptr_q[g];
        endcase
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mode_q   <= 2'b00;
          ptr_q[g] <= '0;
        end else begin
          if (wr_ok && cfg_sel == SEL_MODE)
            mode_q <= cfg_wdata[2*g +: 2];
          if (wr_ok && cfg_sel == 3'(g + 1))
            ptr_q[g] <= cfg_wdata[ADDR_W-1:0];
          else if (upd)
            ptr_q[g] <= nxt;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      size_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (wr_ok && cfg_sel == SEL_MODE)
        size_q <= cfg_wdata[4];
      if (wr_ok && cfg_sel == SEL_CNT)
        cnt_q <= cfg_wdata[CNT_W-1:0];
      else if (upd)
        cnt_q <= cnt_q - CNT_ONE;
      if (wr_ok && cfg_sel == SEL_EN)
        en_q <= cfg_wdata[0];
      else if (upd && last)
        en_q <= 1'b0;
    end
  end

  assign src_addr  = ptr_q[0];
  assign dst_addr  = ptr_q[1];
  assign word_size = size_q;
  assign en        = en_q;
  assign last      = (cnt_q == CNT_ONE);

endmodule

// File: rtl/irq_xfer_req.sv
module irq_xfer_req (
  input  logic clk,
  input  logic rst_n,
  input  logic periph_req,
  input  logic en,
  input  logic idle,
  output logic accept,
  output logic cpu_irq
);

  logic req_q;
  logic pend_q;
  logic rise;

  assign rise    = periph_req && !req_q;
  assign accept  = idle && en && (pend_q || rise);
  assign cpu_irq = periph_req && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= periph_req;
      if (!en)
        pend_q <= 1'b0;
      else if (rise && !accept)
        pend_q <= 1'b1;
      else if (accept)
        pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_xfer_seq.sv
module irq_xfer_seq
  import irq_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              word_size,
  input  logic              last,
  output logic              idle,
  output logic              busy,
  output logic              upd,
  output logic              flag_clr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int BYTE_W = 8;
  localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'({BYTE_W{1'b1}});

  xfer_state_e       state_q, state_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = ST_RD;
      ST_RD:   if (mem_ready) state_d = ST_WR;
      ST_WR:   if (mem_ready) state_d = ST_UPD;
      ST_UPD:                 state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD && mem_ready)
        data_q <= word_size ? mem_rdata : (mem_rdata & BYTE_MASK);
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign busy      = !idle;
  assign upd       = (state_q == ST_UPD);
  assign flag_clr  = upd && !last;
  assign mem_valid = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = mem_we ? dst_addr : src_addr;
  assign mem_wdata = data_q;

endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  localparam int CFG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              periph_req,
  output logic              flag_clr,
  output logic              cpu_irq,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0] dst_addr;
  logic              word_size;
  logic              en;
  logic              last;
  logic              idle;
  logic              upd;
  logic              accept;

  irq_xfer_cfg #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .CFG_W  (CFG_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .upd       (upd),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .word_size (word_size),
    .en        (en),
    .last      (last)
  );

  irq_xfer_req u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_req (periph_req),
    .en         (en),
    .idle       (idle),
    .accept     (accept),
    .cpu_irq    (cpu_irq)
  );

  irq_xfer_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .word_size (word_size),
    .last      (last),
    .idle      (idle),
    .busy      (busy),
    .upd       (upd),
    .flag_clr  (flag_clr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  assign mem_size = word_size;

endmodule

// File: rtl/irq_xfer_engine_chk.sv
module irq_xfer_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              periph_req,
  input logic              flag_clr,
  input logic              cpu_irq,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  // R3: the bus is only used inside a transfer
  a_r3_bus_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  // R8: a completed read is followed by its write
  a_r8_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> (mem_valid && mem_we));

  // R8: a stalled request holds still
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

  // R6: flag clear is a single pulse in the update cycle
  a_r6_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag_clr);

  a_r6_clr_in_update: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> (busy && !mem_valid));

  // R7: the CPU only sees a request that the engine is not serving
  a_r7_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> periph_req);

  a_r7_irq_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> !busy);

endmodule

bind irq_xfer_engine irq_xfer_engine_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .periph_req (periph_req),
  .flag_clr   (flag_clr),
  .cpu_irq    (cpu_irq),
  .busy       (busy),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/irq_xfer_engine_test.sv
`timescale 1ns/1ps
module irq_xfer_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        periph_req = 1'b0;
  logic        flag_clr, cpu_irq, busy;
  logic        mem_valid, mem_we, mem_size;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench reference state
  logic [15:0] m_src, m_dst, last_rd;
  logic [1:0]  m_smode, m_dmode;
  bit          m_word;
  int          rd_cnt = 0, wr_cnt = 0, fc_cnt = 0;
  bit          hold_ready = 1'b0;
  bit          stall_prev = 1'b0;
  logic [15:0] stall_addr, stall_data;
  logic        stall_we;

  irq_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .periph_req(periph_req), .flag_clr(flag_clr),
    .cpu_irq(cpu_irq), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return (a * 16'h3B1D) ^ 16'hC35A;
  endfunction

  function automatic logic [15:0] step_addr(input logic [15:0] a,
                                            input logic [1:0] md, input bit w);
    logic [15:0] s;
    s = w ? 16'd2 : 16'd1;
    if (md == 2'b10) return a + s;
    if (md == 2'b11) return a - s;
    return a;
  endfunction

  assign mem_rdata = pat(mem_addr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus model, peripheral flag clear and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        chk(mem_valid && mem_addr == stall_addr && mem_we == stall_we
            && mem_wdata == stall_data, "R8 held request", mem_addr, stall_addr);
      end
      mem_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
      if (mem_valid && mem_ready) begin
        if (!mem_we) begin
          chk(mem_addr == m_src, "R4/R5 read address", mem_addr, m_src);
          chk(mem_size == m_word, "R5 size", mem_size, m_word);
          last_rd = mem_addr;
          rd_cnt++;
        end else begin
          chk(mem_addr == m_dst, "R4/R5 write address", mem_addr, m_dst);
          chk(mem_wdata == (m_word ? pat(m_src) : (pat(m_src) & 16'h00FF)),
              "R3/R5 write data", mem_wdata,
              m_word ? pat(m_src) : (pat(m_src) & 16'h00FF));
          m_src = step_addr(m_src, m_smode, m_word);
          m_dst = step_addr(m_dst, m_dmode, m_word);
          wr_cnt++;
        end
      end
      stall_prev = mem_valid && !mem_ready;
      stall_addr = mem_addr;
      stall_we   = mem_we;
      stall_data = mem_wdata;
      if (flag_clr) begin
        fc_cnt++;
        periph_req = 1'b0;
      end
    end
  end

  task automatic cfg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic setup(input logic [1:0] sm, input logic [1:0] dm, input bit w,
                       input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] n);
    cfg(3'd0, {11'd0, w, dm, sm});
    cfg(3'd1, s);
    cfg(3'd2, d);
    cfg(3'd3, n);
    cfg(3'd4, 16'd1);
    m_smode = sm; m_dmode = dm; m_word = w; m_src = s; m_dst = d;
  endtask

  task automatic run_scn(input logic [1:0] sm, input logic [1:0] dm, input bit w,
                         input logic [15:0] s, input logic [15:0] d,
                         input int n);
    int fc0, w0;
    setup(sm, dm, w, s, d, 16'(n));
    for (int i = 0; i < n; i++) begin
      fc0 = fc_cnt; w0 = wr_cnt;
      @(negedge clk);
      periph_req = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R3 busy after accept", busy, 1);
      wait_idle();
      chk(wr_cnt == w0 + 1, "R3 one transfer per request", wr_cnt, w0 + 1);
      if (i < n - 1) begin
        chk(fc_cnt == fc0 + 1, "R6 flag clear pulse", fc_cnt, fc0 + 1);
        chk(cpu_irq == 1'b0, "R6 no cpu irq", cpu_irq, 0);
      end else begin
        chk(fc_cnt == fc0, "R7 flag kept on last", fc_cnt, fc0);
        chk(cpu_irq == 1'b1, "R7 cpu irq after last", cpu_irq, 1);
      end
    end
    w0 = wr_cnt;
    repeat (3) @(negedge clk);
    chk(cpu_irq == 1'b1 && wr_cnt == w0, "R7 irq held, no transfer", cpu_irq, 1);
    periph_req = 1'b0;
    @(negedge clk);
    chk(cpu_irq == 1'b0, "R7 irq drops with flag", cpu_irq, 0);
    periph_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_irq == 1'b1 && wr_cnt == w0 && !busy, "R7 enable cleared",
        wr_cnt, w0);
    periph_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int w0;
    void'($urandom(32'd12345));
    m_src = 0; m_dst = 0; m_smode = 0; m_dmode = 0; m_word = 0; last_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_valid && !flag_clr && !cpu_irq, "R1 reset state", busy, 0);

    // R2: disabled engine passes the request straight through
    w0 = wr_cnt;
    periph_req = 1'b1;
    @(negedge clk);
    chk(cpu_irq == 1'b1, "R2 pass-through", cpu_irq, 1);
    repeat (4) @(negedge clk);
    chk(!busy && rd_cnt == 0 && wr_cnt == w0, "R2 no bus access", rd_cnt, 0);
    periph_req = 1'b0;
    @(negedge clk);
    chk(cpu_irq == 1'b0, "R2 pass-through low", cpu_irq, 0);

    // directed: fixed source into incrementing buffer (R4)
    run_scn(2'b00, 2'b10, 1'b0, 16'h00F0, 16'h4000, 5);
    // decrementing words crossing zero (R4, R5)
    run_scn(2'b11, 2'b11, 1'b1, 16'h0002, 16'h0001, 3);
    // incrementing bytes across the top (R5)
    run_scn(2'b10, 2'b10, 1'b0, 16'hFFFE, 16'hFFFF, 4);
    // mode 01 stays fixed, count of one (R4, R7)
    run_scn(2'b01, 2'b01, 1'b1, 16'h1234, 16'h5678, 1);

    // R9: request rising during a transfer is kept pending
    setup(2'b10, 2'b10, 1'b0, 16'h0100, 16'h0200, 16'd3);
    w0 = wr_cnt;
    hold_ready = 1'b1;
    @(negedge clk);
    periph_req = 1'b1;
    repeat (2) @(negedge clk);
    periph_req = 1'b0;
    @(negedge clk);
    periph_req = 1'b1;
    @(negedge clk);
    hold_ready = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (wr_cnt == w0 + 2 && !busy) break;
    end
    repeat (3) @(negedge clk);
    chk(wr_cnt == w0 + 2, "R9 pending request served", wr_cnt, w0 + 2);

    // R10: writes during busy are ignored (last of the three transfers)
    hold_ready = 1'b1;
    @(negedge clk);
    periph_req = 1'b1;
    @(negedge clk);
    cfg(3'd1, 16'h7777);
    cfg(3'd3, 16'd9);
    hold_ready = 1'b0;
    wait_idle();
    chk(last_rd == 16'h0102, "R10 source write ignored", last_rd, 16'h0102);
    chk(cpu_irq == 1'b1, "R10 count write ignored", cpu_irq, 1);
    periph_req = 1'b0;
    @(negedge clk);

    // constrained random scenarios
    for (int r = 0; r < 8; r++) begin
      logic [1:0] sm, dm;
      sm = 2'($urandom % 4);
      dm = 2'($urandom % 4);
      run_scn(sm, dm, 1'($urandom % 2), 16'($urandom), 16'($urandom),
              1 + int'($urandom % 6));
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule